// File: doc/BRIEF.md
# USB VBUS Power Switch Controller

This block drives the enable line of an external regulator that supplies VBUS and watches the power-fault line that the regulator returns. Software programs it through a small register port. A control register holds a host-mode bit, a power-request bit, a polarity bit for the enable pin, a polarity bit for the fault pin and two action bits. One action bit lets a fault remove power in hardware. The other lets a fault raise an interrupt. Either, both or neither may be selected.

The fault pin is synchronized and then filtered, so a short glitch is ignored. A separate VBUS-valid input is synchronized and edge-detected to report device attach (rising edge) and detach (falling edge). All events land in a sticky status register with write-one-to-clear bits. A mask register selects which status bits drive the interrupt line. The enable pin is driven from a flop, is inactive out of reset, and stays inactive in device mode so that a remote host can supply VBUS.

Top module: `vbus_pwr_ctl`

## Requirements
- R1: After reset the enable pin is low and the interrupt line is low. The control register (address 0) reads 0x0C, which means enable active-high, fault active-high and every other bit 0. The status register (address 1) and the mask register (address 2) read 0.
- R2: The control register bit 0 is host mode and bit 1 is the power request. The enable pin is at its active level only while both bits are 1, and it follows a control write by the second clock edge. With bit 0 at 0 (device mode) the pin stays inactive whatever bit 1 holds.
- R3: Control bit 2 selects the active level of the enable pin: 1 means active-high and 0 means active-low.
- R4: Control bit 3 selects the active level of the fault input: 1 means a high input is a fault and 0 means a low input is a fault.
- R5: A fault is recognised only after the synchronized fault input has been at its active level for 4 consecutive clocks. An active pulse of 3 clocks has no effect on the pin or on the status.
- R6: With control bit 4 (auto-off) set, a recognised fault clears the power request bit and drives the pin inactive. Power stays off after the fault ends. While auto-off is set and status bit 0 is set, writes to the request bit are ignored. Power returns only after software clears status bit 0 and writes the request again.
- R7: With control bit 5 (interrupt-on-fault) set, a recognised fault sets status bit 0. With bit 5 clear, status bit 0 stays 0, and without auto-off the pin stays on.
- R8: A rising edge of the synchronized VBUS-valid input sets status bit 1 (attach). A falling edge sets status bit 2 (detach).
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If the setting event is still present in the same cycle, the set wins.
- R10: The interrupt line is the OR over the status bits, each ANDed with the matching bit of the mask register (address 2, bits 2:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 mask, 3 live levels) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| vbus_fault_in | input | 1 | Power-fault line from the external regulator (asynchronous) |
| vbus_valid_in | input | 1 | VBUS-valid level (asynchronous) |
| vbus_en_out | output | 1 | Enable line to the external regulator |
| irq_out | output | 1 | Masked interrupt |

## Verification
The power request is driven with random combinations of host mode, request and enable polarity. This separates device-mode suppression from the polarity inversion. The fault line is given 3-clock and 4-clock pulses, which puts the filter threshold on both sides of its boundary. Each of the four action settings is then run against a held fault, so hardware power removal, status reporting and the blocked re-request are each seen apart. Random VBUS toggles, random masks and random write-one-to-clear patterns then compare the status and interrupt against a bench-kept status image.

// File: rtl/vbus_pwr_pkg.sv
// Shared definitions for the VBUS power switch controller.
// Assumes an 8-bit data path and a 2-bit register address.
package vbus_pwr_pkg;

    localparam int A_CTRL = 0;
    localparam int A_STS  = 1;
    localparam int A_MASK = 2;
    localparam int A_LIVE = 3;

    localparam int ST_FAULT  = 0;
    localparam int ST_ATTACH = 1;
    localparam int ST_DETACH = 2;
    localparam int NUM_ST    = 3;

    // Control register; the field order is the bit order software sees (bit 0 = host_mode).
    typedef struct packed {
        logic irq_on_fault;
        logic auto_off;
        logic flt_pol;
        logic en_pol;
        logic pwr_req;
        logic host_mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{irq_on_fault: 1'b0, auto_off: 1'b0, flt_pol: 1'b1,
                                   en_pol: 1'b1, pwr_req: 1'b0, host_mode: 1'b0};

endpackage

// File: rtl/vbus_in_filter.sv
// Input conditioner: a multi-flop synchronizer, a polarity select, then a
// run-length filter. level_o is high once the input has been active for
// FILT_LEN consecutive clocks, and it drops on the first inactive clock.
// Assumes SYNC_STAGES >= 2 and that raw_i may be fully asynchronous.
module vbus_in_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic act_high_i,
    output logic level_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   act;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    assign act = (sync_q[SYNC_STAGES-1] == act_high_i);

    generate
        if (FILT_LEN <= 1) begin : g_nofilt
            logic lvl_q;
            // Register the polarity-corrected level directly.
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q <= 1'b0;
                else        lvl_q <= act;
            end
            assign level_o = lvl_q;
        end else begin : g_filt
            localparam int CW = $clog2(FILT_LEN + 1);
            logic [CW-1:0] run_q;
            // Count consecutive active clocks, saturating at the threshold.
            always_ff @(posedge clk) begin
                if (!rst_n)                         run_q <= '0;
                else if (!act)                      run_q <= '0;
                else if (run_q != CW'(FILT_LEN))    run_q <= run_q + 1'b1;
            end
            assign level_o = (run_q == CW'(FILT_LEN));

            // R5
            drop_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !act |=> !level_o);
            // R5
            rise_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(level_o) |-> $past(act));
        end
    endgenerate

endmodule

// File: rtl/vbus_evt_detect.sv
// Edge detector for a synchronized level: one-clock pulses on the rising and
// falling edges. Assumes level_i is already synchronous to clk; its idle level
// after reset is low.
module vbus_evt_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Remember the previous level for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/vbus_pwr_regs.sv
// Register file: control, sticky write-one-to-clear status, interrupt mask,
// and a read-only view of live levels. It also applies the hardware
// power-request clear on an auto-off fault. Assumes fault_i, attach_i and
// detach_i are synchronous to clk.
module vbus_pwr_regs
    import vbus_pwr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              fault_i,
    input  logic              attach_i,
    input  logic              detach_i,
    input  logic [2:0]        live_i,
    output ctrl_t             ctrl_o,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    logic [NUM_ST-1:0] sts_q;
    logic [NUM_ST-1:0] msk_q;
    logic [NUM_ST-1:0] sts_set;
    logic [NUM_ST-1:0] sts_clr;
    logic              wr_ctrl, wr_sts, wr_msk;
    logic              trip, req_block;

    assign wr_ctrl   = wr_i && (addr_i == ADDR_W'(A_CTRL));
    assign wr_sts    = wr_i && (addr_i == ADDR_W'(A_STS));
    assign wr_msk    = wr_i && (addr_i == ADDR_W'(A_MASK));
    assign trip      = ctrl_q.auto_off && fault_i;
    assign req_block = ctrl_q.auto_off && sts_q[ST_FAULT];

    // Control register update; the hardware trip overrides any write of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.host_mode    <= wdata_i[0];
                ctrl_q.en_pol       <= wdata_i[2];
                ctrl_q.flt_pol      <= wdata_i[3];
                ctrl_q.auto_off     <= wdata_i[4];
                ctrl_q.irq_on_fault <= wdata_i[5];
                if (!req_block) ctrl_q.pwr_req <= wdata_i[1];
            end
            if (trip) ctrl_q.pwr_req <= 1'b0;
        end
    end

    // Collect status set events and write-one-to-clear requests.
    always_comb begin
        sts_set            = '0;
        sts_set[ST_FAULT]  = fault_i && ctrl_q.irq_on_fault;
        sts_set[ST_ATTACH] = attach_i;
        sts_set[ST_DETACH] = detach_i;
        sts_clr            = wr_sts ? wdata_i[NUM_ST-1:0] : '0;
    end

    // Sticky status; a set event in the same cycle beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= '0;
        else if (wr_msk) msk_q <= wdata_i[NUM_ST-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_CTRL): rdata_o = DATA_W'(ctrl_q);
            ADDR_W'(A_STS):  rdata_o = DATA_W'(sts_q);
            ADDR_W'(A_MASK): rdata_o = DATA_W'(msk_q);
            default:         rdata_o = DATA_W'(live_i);
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = |(sts_q & msk_q);

    // R6
    auto_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.auto_off && fault_i) |=> !ctrl_q.pwr_req);
    // R7
    fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.irq_on_fault && fault_i) |=> sts_q[ST_FAULT]);
    // R8
    attach_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attach_i |=> sts_q[ST_ATTACH]);
    // R8
    detach_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detach_i |=> sts_q[ST_DETACH]);
    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata_i[ST_ATTACH] && !attach_i) |=> !sts_q[ST_ATTACH]);

endmodule

// File: rtl/vbus_pwr_ctl.sv
// VBUS power switch controller top. It conditions the fault and VBUS-valid
// inputs, holds the registers, and drives a registered, polarity-selected
// enable pin. Assumes a single clock domain for the register port; both pin
// inputs may be asynchronous.
module vbus_pwr_ctl
    import vbus_pwr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FAULT_FILT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              vbus_fault_in,
    input  logic              vbus_valid_in,
    output logic              vbus_en_out,
    output logic              irq_out
);

    ctrl_t ctrl;
    logic  fault_lvl, vbus_lvl, attach_p, detach_p;
    logic  pwr_on, en_q;

    vbus_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FAULT_FILT)) u_fault_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(vbus_fault_in),
        .act_high_i(ctrl.flt_pol), .level_o(fault_lvl)
    );

    vbus_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(1)) u_vbus_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(vbus_valid_in),
        .act_high_i(1'b1), .level_o(vbus_lvl)
    );

    vbus_evt_detect u_vbus_evt (
        .clk(clk), .rst_n(rst_n), .level_i(vbus_lvl),
        .rise_o(attach_p), .fall_o(detach_p)
    );

    vbus_pwr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .fault_i(fault_lvl),
        .attach_i(attach_p), .detach_i(detach_p),
        .live_i({fault_lvl, vbus_lvl, pwr_on}), .ctrl_o(ctrl), .irq_o(irq_out)
    );

    assign pwr_on = ctrl.host_mode && ctrl.pwr_req && !(ctrl.auto_off && fault_lvl);

    // Drive the enable pin from a flop at the selected polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= ctrl.en_pol ? pwr_on : !pwr_on;
    end

    assign vbus_en_out = en_q;

    // R2
    device_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl.host_mode) |-> (vbus_en_out == !$past(ctrl.en_pol)));
    // R6
    trip_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.auto_off && fault_lvl) |=> (vbus_en_out == !$past(ctrl.en_pol)));

endmodule

// File: tb/test_vbus_pwr_ctl.sv
module test_vbus_pwr_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       vbus_fault_in = 1'b0;
    logic       vbus_valid_in = 1'b0;
    logic       vbus_en_out;
    logic       irq_out;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic [2:0] exp_sts;
    logic [2:0] exp_msk;
    logic [7:0] rv;

    always #5 clk = ~clk;

    vbus_pwr_ctl i_vbus_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vbus_fault_in(vbus_fault_in), .vbus_valid_in(vbus_valid_in),
        .vbus_en_out(vbus_en_out), .irq_out(irq_out)
    );

    function automatic logic exp_pin(logic [7:0] c);
        logic on;
        on = c[0] & c[1];
        return c[2] ? on : ~on;
    endfunction

    function automatic logic exp_irq(logic [2:0] s, logic [2:0] m);
        return |(s & m);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold the fault line active (high) for n clocks, then release.
    task automatic fault_pulse(input int n);
        @(negedge clk);
        vbus_fault_in = 1'b1;
        wait_clk(n);
        vbus_fault_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        void'($urandom(32'd1234));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        chk(vbus_en_out == 1'b0, "R1 pin", vbus_en_out, 0);
        chk(irq_out == 1'b0, "R1 irq", irq_out, 0);
        rd(0, rv); chk(rv == 8'h0C, "R1 ctrl", rv, 8'h0C);
        rd(1, rv); chk(rv == 8'h00, "R1 status", rv, 0);
        rd(2, rv); chk(rv == 8'h00, "R1 mask", rv, 0);

        // R2 R3: random host/request/polarity combinations, no fault actions
        for (int i = 0; i < 40; i++) begin
            c = {4'b0000, 1'b1, 3'($urandom())};
            wr(0, c);
            wait_clk(1);
            chk(vbus_en_out == exp_pin(c), "R2/R3 pin random", vbus_en_out, exp_pin(c));
        end
        // R2: device mode with request set, active-high
        wr(0, 8'h0E); wait_clk(2);
        chk(vbus_en_out == 1'b0, "R2 device mode off", vbus_en_out, 0);
        // R3: device mode, active-low pin stays high
        wr(0, 8'h0A); wait_clk(2);
        chk(vbus_en_out == 1'b1, "R3 active-low inactive", vbus_en_out, 1);

        // R5 R6 R7: host on, auto-off and irq-on-fault, active-high pin
        wr(0, 8'h3F); wait_clk(2);
        chk(vbus_en_out == 1'b1, "R6 power on", vbus_en_out, 1);
        fault_pulse(3); wait_clk(10);
        chk(vbus_en_out == 1'b1, "R5 3-clock glitch ignored pin", vbus_en_out, 1);
        rd(1, rv); chk(rv == 8'h00, "R5 3-clock glitch ignored status", rv, 0);
        fault_pulse(4); wait_clk(10);
        chk(vbus_en_out == 1'b0, "R5 4-clock fault trips", vbus_en_out, 0);
        rd(1, rv); chk(rv == 8'h01, "R7 fault status set", rv, 1);
        rd(0, rv); chk(rv[1] == 1'b0, "R6 request cleared", rv[1], 0);
        wr(0, 8'h3F); wait_clk(3);
        rd(0, rv); chk(rv[1] == 1'b0, "R6 re-request blocked", rv[1], 0);
        chk(vbus_en_out == 1'b0, "R6 stays off", vbus_en_out, 0);
        wr(1, 8'h01); wait_clk(1);
        rd(1, rv); chk(rv == 8'h00, "R9 fault cleared", rv, 0);
        wr(0, 8'h3F); wait_clk(2);
        chk(vbus_en_out == 1'b1, "R6 power back after clear", vbus_en_out, 1);

        // R7: auto-off only, no status
        wr(0, 8'h1F); wait_clk(2);
        fault_pulse(6); wait_clk(10);
        chk(vbus_en_out == 1'b0, "R6 auto-off only trips", vbus_en_out, 0);
        rd(1, rv); chk(rv == 8'h00, "R7 no status without irq select", rv, 0);
        wr(0, 8'h1F); wait_clk(2);
        chk(vbus_en_out == 1'b1, "R6 re-request without status", vbus_en_out, 1);

        // R7 R9 R10: irq only, fault held, set wins over clear
        wr(2, 8'h01);
        wr(0, 8'h2F); wait_clk(2);
        @(negedge clk); vbus_fault_in = 1'b1;
        wait_clk(10);
        chk(vbus_en_out == 1'b1, "R7 irq only keeps power", vbus_en_out, 1);
        chk(irq_out == 1'b1, "R10 fault irq", irq_out, 1);
        wr(1, 8'h01); wait_clk(1);
        rd(1, rv); chk(rv[0] == 1'b1, "R9 set wins while fault held", rv[0], 1);
        @(negedge clk); vbus_fault_in = 1'b0;
        wait_clk(6);
        wr(1, 8'h01); wait_clk(1);
        rd(1, rv); chk(rv == 8'h00, "R9 clear after fault gone", rv, 0);

        // R4: fault active-low
        wr(0, 8'h07); wait_clk(2);
        @(negedge clk); vbus_fault_in = 1'b1;
        wait_clk(8);
        wr(0, 8'h17); wait_clk(4);
        chk(vbus_en_out == 1'b1, "R4 high is inactive when active-low", vbus_en_out, 1);
        @(negedge clk); vbus_fault_in = 1'b0;
        wait_clk(10);
        chk(vbus_en_out == 1'b0, "R4 low trips when active-low", vbus_en_out, 0);
        wr(0, 8'h0C); wait_clk(10);

        // R8: attach and detach
        wr(2, 8'h00);
        @(negedge clk); vbus_valid_in = 1'b1; wait_clk(8);
        rd(1, rv); chk(rv == 8'h02, "R8 attach", rv, 2);
        @(negedge clk); vbus_valid_in = 1'b0; wait_clk(8);
        rd(1, rv); chk(rv == 8'h06, "R8 detach", rv, 6);
        wr(1, 8'h00); wait_clk(1);
        rd(1, rv); chk(rv == 8'h06, "R9 write zero keeps", rv, 6);
        exp_sts = 3'b110;

        // R8 R9 R10: random toggles, masks and clears
        for (int i = 0; i < 30; i++) begin
            exp_msk = 3'($urandom());
            wr(2, {5'b0, exp_msk});
            if ($urandom() % 2 == 1) begin
                @(negedge clk);
                vbus_valid_in = ~vbus_valid_in;
                if (vbus_valid_in) exp_sts[1] = 1'b1; else exp_sts[2] = 1'b1;
                wait_clk(8);
            end
            if ($urandom() % 2 == 1) begin
                c = {5'b0, 3'($urandom())};
                wr(1, c);
                exp_sts = exp_sts & ~c[2:0];
                wait_clk(1);
            end
            rd(1, rv); chk(rv[2:0] == exp_sts, "R8/R9 random status", rv, exp_sts);
            chk(irq_out == exp_irq(exp_sts, exp_msk), "R10 random irq",
                irq_out, exp_irq(exp_sts, exp_msk));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule